// File: doc/BRIEF.md
# Timer-Latch Short-Circuit Protection

This block guards the boosted supply path of a charge pump and its output regulator. Two digitized comparator flags come in. One reports an output overcurrent and the other an output undervoltage. Each flag passes through a two-flop synchronizer. The two synchronized flags are then ORed into a single short-circuit detect. While the path is running, a masking timer counts the clock edges on which detect is asserted without a break. When the count reaches the programmed masking length, the block drops the run output and sets a latched-fault flag.

The latch is released only by taking enable low. The path then restarts when enable goes high again. Enable low also stops a healthy path, and in that case no fault is recorded. The block also enforces a power-on rule. When the supply-good flag first comes up, enable must be low, or the block refuses to start. It stays refused until the supply drops again or reset is applied. The default masking length is 36000 cycles, which is 18 ms at a 2 MHz tick.

Top module: `scp_guard`

## Requirements
- R1: After reset, `run` and `fault_latched` are both 0, and neither rises until `supply_ok` is seen high.
- R2: If `en` is 0 on the first clock edge at which `supply_ok` is high, a later edge with `en` = 1 sets `run` to 1 after that same edge.
- R3: If `en` is 1 on the first clock edge at which `supply_ok` is high, `run` stays 0 whatever `en` does, until `supply_ok` goes low or reset is applied.
- R4: An edge with `en` = 0 while running clears `run` after that edge and leaves `fault_latched` at 0.
- R5: Detect is the OR of `oc_det` and `uv_det`; either flag alone, held long enough, trips the latch.
- R6: Both flags pass through two synchronizer flops. If detect is 1 from edge k onward while running, `run` is still 1 after edge k+MASK_CYCLES and is 0 after edge k+MASK_CYCLES+1.
- R7: One cycle with detect at 0 restarts the masking count. Runs of MASK_CYCLES-1 detect cycles separated by single gaps never trip.
- R8: Once tripped, `fault_latched` is 1 and `run` is 0, and both hold while `en` and `supply_ok` stay 1, whatever the comparator flags do.
- R9: An edge with `en` = 0 in the tripped state clears `fault_latched` after that edge. A following edge with `en` = 1 sets `run` again.
- R10: An edge with `supply_ok` = 0 forces `run` and `fault_latched` to 0 after that edge. The power-on rule of R2/R3 is then applied again.
- R11: Detect is counted only while running. A fault that is present while stopped adds nothing to the count, so after start-up a full masking interval is needed before a trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz tick clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable request, active high |
| oc_det | input | 1 | Overcurrent comparator flag (asynchronous) |
| uv_det | input | 1 | Undervoltage comparator flag (asynchronous) |
| supply_ok | input | 1 | Supply at or above its good threshold |
| run | output | 1 | Run command to pump and regulator |
| fault_latched | output | 1 | Short-circuit latch set |

## Verification
The bench goes after the exact trip edge. A design that loses or adds a synchronizer stage, or that compares the count one step off, would shut down one cycle early or late. It also sends detect bursts one cycle short of the masking length, separated by single gaps. A design that only pauses the count instead of clearing it would trip on those bursts. The bench also raises `en` before `supply_ok` comes up, and it holds a fault while stopped. A design with a missing power-on check would start when it should stay blocked. A design that counts while idle would trip right after start-up.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [2:0] {
        PS_WAIT_SUPPLY = 3'd0,
        PS_IDLE        = 3'd1,
        PS_RUN         = 3'd2,
        PS_TRIPPED     = 3'd3,
        PS_BLOCKED     = 3'd4
    } prot_state_e;

    typedef struct packed {
        logic oc;
        logic uv;
    } fault_flags_t;

    localparam int FLAG_W = $bits(fault_flags_t);

    // Power-on decision: enable must be low when the supply is first seen good.
    function automatic prot_state_e power_on_target(input logic en_now);
        return en_now ? PS_BLOCKED : PS_IDLE;
    endfunction

    function automatic logic any_fault(input fault_flags_t f);
        return f.oc | f.uv;
    endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/scp_mask_timer.sv
module scp_mask_timer #(
    parameter int MASK_CYCLES = 36000
) (
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  logic detect,
    output logic expire
);
    localparam int CW = (MASK_CYCLES > 2) ? $clog2(MASK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(MASK_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign expire = running && detect && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!running || !detect || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: a gap in detect restarts the masking count
    a_r7_gap_clears: assert property (@(posedge clk) disable iff (rst)
        !detect |=> (cnt == '0));

    // R6: the count never passes the last masking step
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R11: nothing accumulates while stopped
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !running |=> (cnt == '0));
endmodule

// File: rtl/scp_ctrl.sv
module scp_ctrl
    import scp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic supply_ok,
    input  logic expire,
    output logic running,
    output logic tripped
);
    prot_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (!supply_ok) begin
            state_nx = PS_WAIT_SUPPLY;
        end else begin
            unique case (state)
                PS_WAIT_SUPPLY: state_nx = power_on_target(en);
                PS_IDLE:        if (en) state_nx = PS_RUN;
                PS_RUN: begin
                    if (!en)         state_nx = PS_IDLE;
                    else if (expire) state_nx = PS_TRIPPED;
                end
                PS_TRIPPED:     if (!en) state_nx = PS_IDLE;
                PS_BLOCKED:     state_nx = PS_BLOCKED;
                default:        state_nx = PS_WAIT_SUPPLY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_WAIT_SUPPLY;
        else     state <= state_nx;
    end

    assign running = (state == PS_RUN);
    assign tripped = (state == PS_TRIPPED);

    // R3: a failed power-on check holds while supply stays good
    a_r3_blocked_holds: assert property (@(posedge clk) disable iff (rst)
        (state == PS_BLOCKED) && supply_ok |=> (state == PS_BLOCKED));

    // R10: supply loss returns to the power-on wait
    a_r10_supply_loss: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (state == PS_WAIT_SUPPLY));

    // R4: enable low stops without a fault
    a_r4_en_stop: assert property (@(posedge clk) disable iff (rst)
        running && !en |=> !running && !tripped);

    // R8: the latch holds while enable and supply stay high
    a_r8_latch_holds: assert property (@(posedge clk) disable iff (rst)
        tripped && en && supply_ok |=> tripped);

    // R9: enable low releases the latch
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        tripped && !en |=> !tripped);
endmodule

// File: rtl/scp_guard.sv
module scp_guard
    import scp_pkg::*;
#(
    parameter int MASK_CYCLES = 36000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic oc_det,
    input  logic uv_det,
    input  logic supply_ok,
    output logic run,
    output logic fault_latched
);
    fault_flags_t raw_flags, sync_flags;
    logic detect, expire, running, tripped;

    assign raw_flags = '{oc: oc_det, uv: uv_det};

    scp_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_flags),
        .q   (sync_flags)
    );

    assign detect = any_fault(sync_flags);

    scp_mask_timer #(.MASK_CYCLES(MASK_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .running (running),
        .detect  (detect),
        .expire  (expire)
    );

    scp_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .supply_ok (supply_ok),
        .expire    (expire),
        .running   (running),
        .tripped   (tripped)
    );

    assign run           = running;
    assign fault_latched = tripped;

    // R8: run and the latch are never both set
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(run && fault_latched));

    // R5: a trip only follows an asserted detect
    a_r5_trip_cause: assert property (@(posedge clk) disable iff (rst)
        run && !detect |=> !fault_latched);
endmodule

// File: tb/scp_guard_bench.sv
module scp_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int M = 20;

    localparam int S_WAIT = 0, S_IDLE = 1, S_RUN = 2, S_TRIP = 3, S_BLK = 4;

    logic clk = 0, rst = 1, en = 0, oc = 0, uv = 0, sup = 0;
    logic run, fault_latched;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    // reference model state
    int m_st = S_WAIT, m_cnt = 0, m_s1 = 0, m_s2 = 0;

    scp_guard #(.MASK_CYCLES(M), .SYNC_STAGES(2)) u_scp_guard (
        .clk(clk), .rst(rst), .en(en), .oc_det(oc), .uv_det(uv),
        .supply_ok(sup), .run(run), .fault_latched(fault_latched)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_st = S_WAIT; m_cnt = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            int det;
            det  = m_s2;
            m_s2 = m_s1;
            m_s1 = (oc | uv) ? 1 : 0;
            if (!sup) begin
                m_st = S_WAIT; m_cnt = 0;
            end else begin
                case (m_st)
                    S_WAIT: m_st = en ? S_BLK : S_IDLE;
                    S_IDLE: begin m_cnt = 0; if (en) m_st = S_RUN; end
                    S_RUN: begin
                        if (!en) begin m_st = S_IDLE; m_cnt = 0; end
                        else if (det != 0) begin
                            if (m_cnt == M - 1) begin m_st = S_TRIP; m_cnt = 0; end
                            else m_cnt++;
                        end else m_cnt = 0;
                    end
                    S_TRIP: if (!en) m_st = S_IDLE;
                    default: ;
                endcase
            end
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            logic exp_run, exp_flt;
            exp_run = (m_st == S_RUN);
            exp_flt = (m_st == S_TRIP);
            checks++;
            if (run !== exp_run || fault_latched !== exp_flt) begin
                fails++;
                $display("FAIL %s model: run=%b fault=%b expected run=%b fault=%b at %0t",
                         cur_req, run, fault_latched, exp_run, exp_flt, $time);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic er, input logic ef);
        checks++;
        if (run !== er || fault_latched !== ef) begin
            fails++;
            $display("FAIL %s: run=%b fault=%b expected run=%b fault=%b",
                     req, run, fault_latched, er, ef);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run=%b expected completion", run);
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 0;
        cur_req = "R1";
        cyc(2);
        expect_out("R1 reset state", 0, 0);

        // R3: enable already high at supply-good
        cur_req = "R3";
        en = 1; cyc(1); sup = 1; cyc(5);
        expect_out("R3 blocked", 0, 0);
        en = 0; cyc(2); en = 1; cyc(3);
        expect_out("R3 blocked after toggle", 0, 0);

        // R10: supply drop clears the block, R2: proper start
        cur_req = "R10";
        sup = 0; en = 0; cyc(2);
        expect_out("R10 supply low", 0, 0);
        cur_req = "R2";
        sup = 1; cyc(2);
        expect_out("R2 idle", 0, 0);
        en = 1; cyc(1);
        expect_out("R2 start", 1, 0);

        // R4: enable low stops cleanly
        cur_req = "R4";
        cyc(3); en = 0; cyc(1);
        expect_out("R4 stop", 0, 0);
        en = 1; cyc(2);

        // R6/R5: overcurrent trip with exact timing
        cur_req = "R6";
        oc = 1; cyc(M + 1);
        expect_out("R6 not yet tripped", 1, 0);
        cyc(1);
        expect_out("R6 trip edge", 0, 1);

        // R8: latch holds with flags cleared
        cur_req = "R8";
        oc = 0; cyc(10);
        expect_out("R8 latch holds", 0, 1);
        uv = 1; cyc(3); uv = 0; cyc(3);
        expect_out("R8 latch ignores flags", 0, 1);

        // R9: release and restart
        cur_req = "R9";
        en = 0; cyc(1);
        expect_out("R9 release", 0, 0);
        en = 1; cyc(1);
        expect_out("R9 restart", 1, 0);

        // R5: undervoltage alone trips
        cur_req = "R5";
        uv = 1; cyc(M + 4);
        expect_out("R5 uv trip", 0, 1);
        uv = 0; en = 0; cyc(2); en = 1; cyc(3);

        // R7: bursts one short of the mask with single gaps
        cur_req = "R7";
        for (int r = 0; r < 8; r++) begin
            if (r % 2 == 0) oc = 1; else uv = 1;
            cyc(M - 1);
            oc = 0; uv = 0;
            cyc(1);
        end
        cyc(3);
        expect_out("R7 no trip on gapped bursts", 1, 0);

        // R11: fault while stopped does not count
        cur_req = "R11";
        en = 0; oc = 1; cyc(M + 10);
        expect_out("R11 idle with fault", 0, 0);
        en = 1; cyc(M);
        expect_out("R11 full interval needed", 1, 0);
        cyc(3);
        expect_out("R11 trips after interval", 0, 1);

        // R10: supply loss clears the latch
        cur_req = "R10";
        oc = 0; sup = 0; cyc(1);
        expect_out("R10 latch cleared by supply loss", 0, 0);
        sup = 1; cyc(3);
        expect_out("R10 blocked with en high at supply-good", 0, 0);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule